// File: doc/BRIEF.md
# LCD Timing And Status Controller

This block produces the dot and scanline timebase for a 160 by 144 pixel LCD. A line is a fixed number of system clocks long. The frame holds the visible lines followed by a run of blanking lines, which gives a refresh rate close to 59.73 Hz at the default settings. On every visible line the block moves through three phases in a fixed order: object-memory search, then data transfer to the panel, then horizontal blank. Every line after the visible area is a vertical-blank line. The current phase is reported as a two-bit mode code, and the current line and dot position are output alongside it.

A host reads and writes four byte-wide registers through a simple port: display control, status, current line and line compare. The status register combines four interrupt-enable bits with a live coincidence flag and the mode code. From these the block raises a one-cycle status interrupt request and a one-cycle vertical-blank request. Clearing the top bit of the control register stops the display: the counters are held at zero and the mode reads horizontal blank until the bit is set again.

Top module: `lcd_timing_ctrl`

## Requirements
- R1: After a synchronous reset, control reads 0x91, compare reads 0x00, line and dot are 0, and the mode is 10 (object-memory search). Status therefore reads 0x06: mode 10 with the coincidence flag set, because line 0 equals compare 0.
- R2: While the display is on, every line lasts DOTS_PER_LINE clocks and the dot output counts up by one per clock. On lines below VISIBLE_LINES the mode is 10 for the first SEARCH_DOTS dots, 11 for the next XFER_DOTS dots and 00 for the rest of the line.
- R3: Lines VISIBLE_LINES to TOTAL_LINES-1 are in mode 01 for the whole line. After line TOTAL_LINES-1 the line count returns to 0.
- R4: irq_vblank is high for exactly one clock, at dot 0 of line VISIBLE_LINES, once per frame.
- R5: Status bit 2 reads 1 exactly while the current line equals the compare register.
- R6: Status bits 6, 5, 4 and 3 enable the status interrupt on line coincidence, mode 10, mode 01 and mode 00 respectively. irq_stat pulses for one clock when the OR of the enabled conditions rises from 0 to 1. Sources that overlap or follow each other with no gap produce only one pulse.
- R7: A write to the line register is ignored, and the line keeps following the timebase. The compare register reads back the value written to it.
- R8: While control bit 7 is 0, the mode reads 00 and, from the next clock on, the line and dot are held at 0 and no vertical-blank request occurs. When the bit is set again, timing restarts at line 0, dot 0, in mode 10.
- R9: A write to status changes only bits 6 to 3. Bits 2 to 0 always show the coincidence flag and the mode, and bit 7 reads 0.
- R10: The register address selects control (0), status (1), line (2) or compare (3). A write takes effect at the clock edge on which reg_wr is high. reg_rdata is a combinational read of the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, one dot per cycle |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 line, 3 compare |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| lcd_mode | output | 2 | Current phase: 00 h-blank, 01 v-blank, 10 search, 11 transfer |
| lcd_line | output | 8 | Current line number |
| lcd_dot | output | DOT_W | Dot position within the current line |
| irq_vblank | output | 1 | One-clock vertical-blank interrupt request |
| irq_stat | output | 1 | One-clock status interrupt request |

## Verification
The assertions check properties that must hold on every clock:
- the dot advances by one per clock while the display runs;
- mode 11 is entered only from mode 10;
- every line at or beyond the visible area reads mode 01, and the line never leaves its range;
- neither interrupt request stays high for two clocks running;
- a stopped display reads mode 00 with both counters held at zero.

The bench scenarios cover what depends on register history and on exact cycle positions:
- each phase and the vertical-blank pulse fall on the expected clock over two whole frames;
- the coincidence flag follows a programmed compare value;
- writes to the line register are ignored, and writes to status leave its low bits unchanged;
- timing restarts cleanly when the display is switched back on;
- merged interrupt sources give a single status pulse.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    localparam int LINE_W = 8;
    localparam logic [7:0] CTRL_RESET = 8'h91;

    typedef enum logic [1:0] {
        PH_HBLANK = 2'b00,
        PH_VBLANK = 2'b01,
        PH_SEARCH = 2'b10,
        PH_XFER   = 2'b11
    } lcd_phase_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_LINE = 2'd2,
        SEL_CMP  = 2'd3
    } reg_sel_e;

    // Interrupt source enables, MSB first: status bits 6..3
    typedef struct packed {
        logic on_coin;
        logic on_search;
        logic on_vblank;
        logic on_hblank;
    } stat_en_t;

    function automatic logic [7:0] pack_status(stat_en_t en, logic coin, lcd_phase_e ph);
        return {1'b0, en, coin, ph};
    endfunction

endpackage

// File: rtl/lcd_timebase.sv
module lcd_timebase
    import lcd_pkg::*;
#(
    parameter int DOTS_PER_LINE = 456,
    parameter int TOTAL_LINES   = 154,
    parameter int DOT_W         = $clog2(DOTS_PER_LINE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    output logic [DOT_W-1:0]  dot,
    output logic [LINE_W-1:0] line
);

    localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(DOTS_PER_LINE - 1);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            dot  <= '0;
            line <= '0;
        end else if (dot == LAST_DOT) begin
            dot  <= '0;
            line <= (line == LAST_LINE) ? '0 : line + LINE_W'(1);
        end else begin
            dot <= dot + DOT_W'(1);
        end
    end

endmodule

// File: rtl/lcd_phase_decode.sv
module lcd_phase_decode
    import lcd_pkg::*;
#(
    parameter int VISIBLE_LINES = 144,
    parameter int SEARCH_DOTS   = 80,
    parameter int XFER_DOTS     = 172,
    parameter int DOT_W         = 9
) (
    input  logic              run,
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    output lcd_phase_e        phase
);

    localparam logic [LINE_W-1:0] VIS_L    = LINE_W'(VISIBLE_LINES);
    localparam logic [DOT_W-1:0]  XFER_BEG = DOT_W'(SEARCH_DOTS);
    localparam logic [DOT_W-1:0]  XFER_END = DOT_W'(SEARCH_DOTS + XFER_DOTS);

    always_comb begin
        if (!run)                phase = PH_HBLANK;
        else if (line >= VIS_L)  phase = PH_VBLANK;
        else if (dot < XFER_BEG) phase = PH_SEARCH;
        else if (dot < XFER_END) phase = PH_XFER;
        else                     phase = PH_HBLANK;
    end

endmodule

// File: rtl/lcd_irq_gen.sv
module lcd_irq_gen
    import lcd_pkg::*;
#(
    parameter int VISIBLE_LINES = 144,
    parameter int DOT_W         = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  lcd_phase_e        phase,
    input  logic              coin,
    input  stat_en_t          en,
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    output logic              irq_stat,
    output logic              irq_vblank
);

    localparam logic [LINE_W-1:0] VIS_L = LINE_W'(VISIBLE_LINES);

    logic cond, cond_q;

    always_comb begin
        cond = (en.on_coin   && coin)
            || (en.on_search && phase == PH_SEARCH)
            || (en.on_vblank && phase == PH_VBLANK)
            || (en.on_hblank && phase == PH_HBLANK);
    end

    always_ff @(posedge clk) begin
        if (rst) cond_q <= 1'b0;
        else     cond_q <= cond;
    end

    assign irq_stat   = cond && !cond_q;
    assign irq_vblank = run && (line == VIS_L) && (dot == '0);

endmodule

// File: rtl/lcd_timing_ctrl.sv
module lcd_timing_ctrl
    import lcd_pkg::*;
#(
    parameter int DOTS_PER_LINE = 456,
    parameter int VISIBLE_LINES = 144,
    parameter int TOTAL_LINES   = 154,
    parameter int SEARCH_DOTS   = 80,
    parameter int XFER_DOTS     = 172,
    parameter int DOT_W         = $clog2(DOTS_PER_LINE)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic [1:0]       lcd_mode,
    output logic [7:0]       lcd_line,
    output logic [DOT_W-1:0] lcd_dot,
    output logic             irq_vblank,
    output logic             irq_stat
);

    logic [7:0]  ctrl_q;
    stat_en_t    en_q;
    logic [7:0]  cmp_q;
    logic        lcd_on;
    logic        coin;
    lcd_phase_e  phase;
    reg_sel_e    sel;

    assign sel    = reg_sel_e'(reg_addr);
    assign lcd_on = ctrl_q[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            en_q   <= '0;
            cmp_q  <= '0;
        end else if (reg_wr) begin
            case (sel)
                SEL_CTRL: ctrl_q <= reg_wdata;
                SEL_STAT: en_q   <= stat_en_t'(reg_wdata[6:3]);
                SEL_CMP:  cmp_q  <= reg_wdata;
                default:  ;
            endcase
        end
    end

    lcd_timebase #(
        .DOTS_PER_LINE(DOTS_PER_LINE),
        .TOTAL_LINES  (TOTAL_LINES),
        .DOT_W        (DOT_W)
    ) u_timebase (
        .clk (clk),
        .rst (rst),
        .run (lcd_on),
        .dot (lcd_dot),
        .line(lcd_line)
    );

    lcd_phase_decode #(
        .VISIBLE_LINES(VISIBLE_LINES),
        .SEARCH_DOTS  (SEARCH_DOTS),
        .XFER_DOTS    (XFER_DOTS),
        .DOT_W        (DOT_W)
    ) u_phase (
        .run  (lcd_on),
        .dot  (lcd_dot),
        .line (lcd_line),
        .phase(phase)
    );

    assign coin     = (lcd_line == cmp_q);
    assign lcd_mode = phase;

    lcd_irq_gen #(
        .VISIBLE_LINES(VISIBLE_LINES),
        .DOT_W        (DOT_W)
    ) u_irq (
        .clk       (clk),
        .rst       (rst),
        .run       (lcd_on),
        .phase     (phase),
        .coin      (coin),
        .en        (en_q),
        .dot       (lcd_dot),
        .line      (lcd_line),
        .irq_stat  (irq_stat),
        .irq_vblank(irq_vblank)
    );

    always_comb begin
        case (sel)
            SEL_CTRL: reg_rdata = ctrl_q;
            SEL_STAT: reg_rdata = pack_status(en_q, coin, phase);
            SEL_LINE: reg_rdata = lcd_line;
            default:  reg_rdata = cmp_q;
        endcase
    end

endmodule

// File: rtl/lcd_timing_ctrl_chk.sv
module lcd_timing_ctrl_chk #(
    parameter int DOTS_PER_LINE = 456,
    parameter int VISIBLE_LINES = 144,
    parameter int TOTAL_LINES   = 154,
    parameter int DOT_W         = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             lcd_on,
    input logic [1:0]       lcd_mode,
    input logic [7:0]       lcd_line,
    input logic [DOT_W-1:0] lcd_dot,
    input logic             irq_vblank,
    input logic             irq_stat
);

    logic past_valid;
    always_ff @(posedge clk) begin
        if (rst) past_valid <= 1'b0;
        else     past_valid <= 1'b1;
    end

    AST_OFF_MODE_HBLANK: assert property (@(posedge clk) disable iff (rst)
        !lcd_on |-> lcd_mode == 2'b00);  // R8

    AST_OFF_COUNTERS_HELD: assert property (@(posedge clk) disable iff (rst)
        (past_valid && !lcd_on && !$past(lcd_on)) |-> (lcd_dot == '0 && lcd_line == '0));  // R8

    AST_DOT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (past_valid && lcd_on && $past(lcd_on) && $past(lcd_dot) != DOT_W'(DOTS_PER_LINE - 1))
        |-> lcd_dot == $past(lcd_dot) + DOT_W'(1));  // R2

    AST_XFER_AFTER_SEARCH: assert property (@(posedge clk) disable iff (rst)
        (past_valid && lcd_mode == 2'b11) |-> ($past(lcd_mode) == 2'b10 || $past(lcd_mode) == 2'b11));  // R2

    AST_VBLANK_LINES_MODE: assert property (@(posedge clk) disable iff (rst)
        (lcd_on && lcd_line >= 8'(VISIBLE_LINES)) |-> lcd_mode == 2'b01);  // R3

    AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        lcd_line < 8'(TOTAL_LINES));  // R3

    AST_VBLANK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq_vblank |=> !irq_vblank);  // R4

    AST_STAT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq_stat |=> !irq_stat);  // R6

endmodule

bind lcd_timing_ctrl lcd_timing_ctrl_chk #(
    .DOTS_PER_LINE(DOTS_PER_LINE),
    .VISIBLE_LINES(VISIBLE_LINES),
    .TOTAL_LINES  (TOTAL_LINES),
    .DOT_W        (DOT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lcd_on    (lcd_on),
    .lcd_mode  (lcd_mode),
    .lcd_line  (lcd_line),
    .lcd_dot   (lcd_dot),
    .irq_vblank(irq_vblank),
    .irq_stat  (irq_stat)
);

// File: tb/tb_lcd_timing_ctrl.sv
module tb_lcd_timing_ctrl;

    localparam int DOTS   = 20;
    localparam int VIS    = 4;
    localparam int TOTAL  = 6;
    localparam int SEARCH = 4;
    localparam int XFER   = 6;
    localparam int DW     = $clog2(DOTS);
    localparam int FRAME  = DOTS * TOTAL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    reg_addr = 2'd0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = 8'h00;
    logic [7:0]    reg_rdata;
    logic [1:0]    lcd_mode;
    logic [7:0]    lcd_line;
    logic [DW-1:0] lcd_dot;
    logic          irq_vblank;
    logic          irq_stat;

    int n_chk  = 0;
    int n_fail = 0;

    lcd_timing_ctrl #(
        .DOTS_PER_LINE(DOTS),
        .VISIBLE_LINES(VIS),
        .TOTAL_LINES  (TOTAL),
        .SEARCH_DOTS  (SEARCH),
        .XFER_DOTS    (XFER)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lcd_mode  (lcd_mode),
        .lcd_line  (lcd_line),
        .lcd_dot   (lcd_dot),
        .irq_vblank(irq_vblank),
        .irq_stat  (irq_stat)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_mode(input int d, input int l);
        if (l >= VIS)         return 1;
        if (d < SEARCH)       return 2;
        if (d < SEARCH + XFER) return 3;
        return 0;
    endfunction

    task automatic reset_dut();
        rst = 1'b1;
        reg_wr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        reset_dut();
        rd(2'd0, v); chk("R1", "control after reset", v, 8'h91);
        rd(2'd3, v); chk("R1", "compare after reset", v, 8'h00);
        rd(2'd1, v); chk("R1", "status after reset", v, 8'h06);
        rd(2'd2, v); chk("R10", "line register read", v, 8'h00);
        chk("R1", "mode after reset", lcd_mode, 2);
        chk("R1", "dot after reset", lcd_dot, 0);
    endtask

    task automatic t_frame_walk();
        reset_dut();
        for (int k = 0; k < 2 * FRAME; k++) begin
            int d = k % DOTS;
            int l = (k / DOTS) % TOTAL;
            chk("R2", "dot", lcd_dot, d);
            chk("R3", "line", lcd_line, l);
            chk("R2", "mode", lcd_mode, exp_mode(d, l));
            chk("R4", "vblank request", irq_vblank, (l == VIS && d == 0) ? 1 : 0);
            adv(1);
        end
    endtask

    task automatic t_compare();
        logic [7:0] v;
        reset_dut();
        wr(2'd3, 8'h02);
        rd(2'd3, v); chk("R7", "compare readback", v, 8'h02);
        adv(44);
        rd(2'd1, v); chk("R5", "status on matching line", v, 8'h07);
        adv(20);
        rd(2'd1, v); chk("R5", "status on next line", v, 8'h03);
    endtask

    task automatic t_line_read_only();
        logic [7:0] v;
        reset_dut();
        adv(45);
        wr(2'd2, 8'h55);
        rd(2'd2, v); chk("R7", "line after ignored write", v, 8'h02);
        chk("R7", "line port after ignored write", lcd_line, 2);
    endtask

    task automatic t_status_write();
        logic [7:0] v;
        reset_dut();
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R9", "status after all-ones write", v, 8'h7E);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R9", "status after zero write", v, 8'h06);
    endtask

    task automatic t_stat_merge();
        reset_dut();
        wr(2'd1, 8'h18);
        for (int k = 1; k < 140; k++) begin
            int e = (k == 10 || k == 30 || k == 50 || k == 70 || k == 130) ? 1 : 0;
            chk("R6", $sformatf("merged status pulse at %0d", k), irq_stat, e);
            adv(1);
        end
    endtask

    task automatic t_stat_coin();
        reset_dut();
        wr(2'd3, 8'h02);
        wr(2'd1, 8'h40);
        for (int k = 2; k < FRAME; k++) begin
            chk("R6", $sformatf("coincidence pulse at %0d", k), irq_stat, (k == 40) ? 1 : 0);
            adv(1);
        end
    endtask

    task automatic t_display_off();
        logic [7:0] v;
        reset_dut();
        adv(25);
        wr(2'd0, 8'h11);
        chk("R8", "mode just after stop", lcd_mode, 0);
        rd(2'd1, v); chk("R8", "status mode bits after stop", v & 8'h03, 0);
        rd(2'd0, v); chk("R10", "control readback", v, 8'h11);
        adv(1);
        for (int k = 0; k < 200; k++) begin
            chk("R8", "dot held", lcd_dot, 0);
            chk("R8", "line held", lcd_line, 0);
            chk("R8", "mode while off", lcd_mode, 0);
            chk("R8", "no vblank while off", irq_vblank, 0);
            adv(1);
        end
        wr(2'd0, 8'h91);
        chk("R8", "mode on restart", lcd_mode, 2);
        chk("R8", "dot on restart", lcd_dot, 0);
        chk("R8", "line on restart", lcd_line, 0);
        adv(1);
        chk("R8", "dot after restart", lcd_dot, 1);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_frame_walk();
        t_compare();
        t_line_read_only();
        t_status_write();
        t_stat_merge();
        t_stat_coin();
        t_display_off();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule